// File: doc/BRIEF.md
# SPI TPM Frame Tracker with Completion Interrupts

This block sits on the target side of a SPI link that carries TPM-style register transactions. It oversamples chip select, serial clock and MOSI in the system clock domain and splits each frame into its parts. A frame is a command byte, three address bytes, a wait byte and a ready byte, followed by the payload. Payload bytes of a write frame go into a write FIFO that local firmware drains. For read frames the block returns a byte taken from a simple data input.

Three events are kept as sticky interrupt status bits. The first is header done, after the command and the address. The second is write done, when chip select rises after a write frame whose header was complete. The third is read done, as soon as the header of a read frame is in. With these events, firmware can sleep through a long transfer instead of polling the FIFO depth or the chip select pin. The FIFO depth is still visible for code that prefers to poll it.

Top module: `spi_tpm_cmpl`

## Requirements
- R1: The command byte gives the direction in bit 7 (1 = read, 0 = write) and the payload length minus one in bits 5:0. Write payload bytes beyond that length are not stored, and read frames never store anything.
- R2: The three address bytes follow the command byte, most significant first, and appear on `frame_addr_o`. MISO returns 0x00 during byte index 4 and 0x01 during byte index 5. The payload starts at byte index 6.
- R3: Status bit 0 (header done) is set once the fourth byte of a frame has been received.
- R4: Status bit 1 (write done) is set when chip select deasserts after a write frame with a complete header, and never earlier.
- R5: Status bit 2 (read done) is set together with header done for a read command, while chip select is still low.
- R6: If chip select deasserts before the header is complete, the frame is dropped: no status bit is set and nothing is stored. The byte counters restart, so the next frame decodes from its first byte.
- R7: Write payload bytes enter the FIFO in arrival order. `wf_depth_o` shows the fill level, up to the full depth of 64. A pop returns the oldest byte on `wf_rdata_o` one cycle later.
- R8: A byte that arrives while the FIFO is full is dropped, and the stored contents and the depth stay unchanged.
- R9: The status bits are sticky. Writing a one to a bit of `irq_clr_i` clears that bit only, and the other bits are kept.
- R10: `irq_o` is the registered OR of the status bits that are enabled in `irq_en_i`. It stays low when no enabled bit is set.
- R11: SPI runs in mode 0, with MOSI sampled on the rising SCK edge. During a read payload, MISO shifts out `rd_byte_i` most significant bit first, and changes only after falling edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_csb_i | input | 1 | SPI chip select, active low |
| spi_sck_i | input | 1 | SPI serial clock |
| spi_mosi_i | input | 1 | SPI data from host |
| spi_miso_o | output | 1 | SPI data to host |
| rd_byte_i | input | 8 | Byte returned during a read payload |
| wf_pop_i | input | 1 | Pop one byte from the write FIFO |
| wf_rdata_o | output | 8 | Byte popped from the FIFO, valid one cycle after the pop |
| wf_depth_o | output | 7 | Current FIFO fill level |
| irq_en_i | input | 3 | Enable per status bit |
| irq_clr_i | input | 3 | Write-one-to-clear strobes per status bit |
| irq_status_o | output | 3 | Sticky status: bit 0 header, bit 1 write done, bit 2 read done |
| irq_o | output | 1 | Interrupt line |
| frame_cmd_o | output | 8 | Last command byte received |
| frame_addr_o | output | 24 | Last address received |

## Verification
The assertions assume that the SPI inputs change slowly compared with the system clock. Each SCK level must last several system cycles, so that the two-flop synchronizers see every edge. They also assume that software never asserts a clear and the matching event in the same cycle, except where set is meant to win. The bench meets the first assumption by holding each SCK phase for eight system cycles and each chip select edge for longer. Clear strobes are only issued when no frame is in flight.

// File: rtl/spi_tpm_pkg.sv
package spi_tpm_pkg;
  localparam int unsigned IRQ_N     = 3;
  localparam int unsigned IRQ_HDR   = 0;
  localparam int unsigned IRQ_WR    = 1;
  localparam int unsigned IRQ_RD    = 2;
  localparam int unsigned ADDR_LAST = 3;  // index of final address byte
  localparam int unsigned WAIT_IDX  = 4;
  localparam int unsigned READY_IDX = 5;
  localparam int unsigned PAY_START = 6;
  localparam logic [7:0]  WAIT_VAL  = 8'h00;
  localparam logic [7:0]  READY_VAL = 8'h01;
endpackage

// File: rtl/spi_tpm_rx.sv
module spi_tpm_rx #(
  parameter int unsigned CNT_W   = 7,
  parameter int unsigned CNT_MAX = 70
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             csb_i,
  input  logic             sck_i,
  input  logic             mosi_i,
  input  logic [7:0]       tx_byte_i,
  output logic             miso_o,
  output logic             byte_vld_o,
  output logic [7:0]       byte_o,
  output logic [CNT_W-1:0] byte_idx_o,
  output logic [CNT_W-1:0] byte_cnt_o,
  output logic             cs_end_o
);
  logic [1:0] csb_sync, sck_sync, mosi_sync;
  logic       sck_q, csb_q;
  logic       csb_s, sck_s, mosi_s, sck_rise, sck_fall;
  logic [2:0] bit_cnt;
  logic [6:0] sh;
  logic [7:0] tx_sr;
  logic       load_pend;

  assign csb_s    = csb_sync[1];
  assign sck_s    = sck_sync[1];
  assign mosi_s   = mosi_sync[1];
  assign sck_rise = sck_s & ~sck_q & ~csb_s;
  assign sck_fall = ~sck_s & sck_q & ~csb_s;
  assign miso_o   = tx_sr[7];

  always_ff @(posedge clk) begin
    if (rst) begin
      csb_sync  <= 2'b11;
      sck_sync  <= 2'b00;
      mosi_sync <= 2'b00;
      sck_q     <= 1'b0;
      csb_q     <= 1'b1;
      cs_end_o  <= 1'b0;
    end else begin
      csb_sync  <= {csb_sync[0], csb_i};
      sck_sync  <= {sck_sync[0], sck_i};
      mosi_sync <= {mosi_sync[0], mosi_i};
      sck_q     <= sck_s;
      csb_q     <= csb_s;
      cs_end_o  <= csb_s & ~csb_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || csb_s) begin
      bit_cnt    <= '0;
      sh         <= '0;
      byte_cnt_o <= '0;
      byte_vld_o <= 1'b0;
      load_pend  <= 1'b0;
      tx_sr      <= '0;
      if (rst) begin
        byte_o     <= '0;
        byte_idx_o <= '0;
      end
    end else begin
      byte_vld_o <= 1'b0;
      if (sck_rise) begin
        sh      <= {sh[5:0], mosi_s};
        bit_cnt <= bit_cnt + 3'd1;
        if (bit_cnt == 3'd7) begin
          byte_vld_o <= 1'b1;
          byte_o     <= {sh, mosi_s};
          byte_idx_o <= byte_cnt_o;
          load_pend  <= 1'b1;
          if (byte_cnt_o != CNT_W'(CNT_MAX)) byte_cnt_o <= byte_cnt_o + 1'b1;
        end
      end else if (sck_fall) begin
        if (load_pend) begin
          tx_sr     <= tx_byte_i;
          load_pend <= 1'b0;
        end else begin
          tx_sr <= {tx_sr[6:0], 1'b0};
        end
      end
    end
  end

  a_r11_miso_on_fall: assert property (@(posedge clk) disable iff (rst)
    (!$past(sck_fall) && !$past(csb_s) && !csb_s) |-> $stable(miso_o));
endmodule

// File: rtl/spi_tpm_frame.sv
module spi_tpm_frame
  import spi_tpm_pkg::*;
#(
  parameter int unsigned CNT_W = 7,
  parameter int unsigned LEN_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             byte_vld_i,
  input  logic [7:0]       byte_i,
  input  logic [CNT_W-1:0] byte_idx_i,
  input  logic [CNT_W-1:0] byte_cnt_i,
  input  logic             cs_end_i,
  input  logic [7:0]       rd_byte_i,
  output logic [7:0]       tx_byte_o,
  output logic             push_o,
  output logic [7:0]       push_data_o,
  output logic [IRQ_N-1:0] ev_o,
  output logic [7:0]       cmd_o,
  output logic [23:0]      addr_o
);
  logic hdr_q;
  logic in_len;

  assign in_len = (byte_idx_i - CNT_W'(PAY_START)) <= CNT_W'(cmd_o[LEN_W-1:0]);

  always_comb begin
    if (byte_cnt_i == CNT_W'(WAIT_IDX))            tx_byte_o = WAIT_VAL;
    else if (byte_cnt_i == CNT_W'(READY_IDX))      tx_byte_o = READY_VAL;
    else if (byte_cnt_i >= CNT_W'(PAY_START) && cmd_o[7]) tx_byte_o = rd_byte_i;
    else                                           tx_byte_o = 8'h00;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hdr_q       <= 1'b0;
      push_o      <= 1'b0;
      push_data_o <= '0;
      ev_o        <= '0;
      cmd_o       <= '0;
      addr_o      <= '0;
    end else begin
      push_o <= 1'b0;
      ev_o   <= '0;
      if (cs_end_i) begin
        if (hdr_q && !cmd_o[7]) ev_o[IRQ_WR] <= 1'b1;
        hdr_q <= 1'b0;
      end else if (byte_vld_i) begin
        if (byte_idx_i == '0) begin
          cmd_o <= byte_i;
        end else if (byte_idx_i <= CNT_W'(ADDR_LAST)) begin
          addr_o <= {addr_o[15:0], byte_i};
          if (byte_idx_i == CNT_W'(ADDR_LAST)) begin
            hdr_q         <= 1'b1;
            ev_o[IRQ_HDR] <= 1'b1;
            ev_o[IRQ_RD]  <= cmd_o[7];
          end
        end else if (byte_idx_i >= CNT_W'(PAY_START) && hdr_q && !cmd_o[7] && in_len) begin
          push_o      <= 1'b1;
          push_data_o <= byte_i;
        end
      end
    end
  end

  a_r4_wr_after_cs_end: assert property (@(posedge clk) disable iff (rst)
    ev_o[IRQ_WR] |-> $past(cs_end_i));
  a_r5_rd_with_hdr: assert property (@(posedge clk) disable iff (rst)
    ev_o[IRQ_RD] |-> ev_o[IRQ_HDR]);
  a_r1_push_only_write: assert property (@(posedge clk) disable iff (rst)
    push_o |-> !cmd_o[7]);
  a_r3_hdr_from_byte: assert property (@(posedge clk) disable iff (rst)
    ev_o[IRQ_HDR] |-> $past(byte_vld_i));
endmodule

// File: rtl/spi_tpm_fifo.sv
module spi_tpm_fifo #(
  parameter int unsigned DW    = 8,
  parameter int unsigned DEPTH = 64
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     push_i,
  input  logic [DW-1:0]            wdata_i,
  input  logic                     pop_i,
  output logic [DW-1:0]            rdata_o,
  output logic [$clog2(DEPTH):0]   depth_o
);
  localparam int unsigned AW = $clog2(DEPTH);

  logic [DW-1:0] mem [DEPTH];
  logic [AW:0]   wp, rp;
  logic          full, empty, do_push, do_pop;

  assign depth_o = wp - rp;
  assign full    = depth_o == (AW+1)'(DEPTH);
  assign empty   = wp == rp;
  assign do_push = push_i & ~full;
  assign do_pop  = pop_i & ~empty;

  always_ff @(posedge clk) begin
    if (do_push) mem[wp[AW-1:0]] <= wdata_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp      <= '0;
      rp      <= '0;
      rdata_o <= '0;
    end else begin
      if (do_push) wp <= wp + 1'b1;
      if (do_pop) begin
        rdata_o <= mem[rp[AW-1:0]];
        rp      <= rp + 1'b1;
      end
    end
  end

  a_r8_no_overflow: assert property (@(posedge clk) disable iff (rst)
    (full && push_i && !pop_i) |=> (depth_o == (AW+1)'(DEPTH)));
  a_r7_depth_bound: assert property (@(posedge clk) disable iff (rst)
    depth_o <= (AW+1)'(DEPTH));
endmodule

// File: rtl/spi_tpm_irq.sv
module spi_tpm_irq #(
  parameter int unsigned N = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] ev_i,
  input  logic [N-1:0] en_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] status_o,
  output logic         irq_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      status_o <= '0;
      irq_o    <= 1'b0;
    end else begin
      status_o <= (status_o & ~clr_i) | ev_i;  // a new event wins over a clear
      irq_o    <= |(status_o & en_i);
    end
  end

  a_r9_hold: assert property (@(posedge clk) disable iff (rst)
    (ev_i == '0 && clr_i == '0) |=> $stable(status_o));
  a_r9_set: assert property (@(posedge clk) disable iff (rst)
    (ev_i != '0) |=> ((status_o & $past(ev_i)) == $past(ev_i)));
  a_r10_gate: assert property (@(posedge clk) disable iff (rst)
    (en_i == '0) |=> !irq_o);
endmodule

// File: rtl/spi_tpm_cmpl.sv
module spi_tpm_cmpl
  import spi_tpm_pkg::*;
#(
  parameter int unsigned FIFO_DEPTH = 64,
  parameter int unsigned MAX_LEN    = 64
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          spi_csb_i,
  input  logic                          spi_sck_i,
  input  logic                          spi_mosi_i,
  output logic                          spi_miso_o,
  input  logic [7:0]                    rd_byte_i,
  input  logic                          wf_pop_i,
  output logic [7:0]                    wf_rdata_o,
  output logic [$clog2(FIFO_DEPTH):0]   wf_depth_o,
  input  logic [IRQ_N-1:0]              irq_en_i,
  input  logic [IRQ_N-1:0]              irq_clr_i,
  output logic [IRQ_N-1:0]              irq_status_o,
  output logic                          irq_o,
  output logic [7:0]                    frame_cmd_o,
  output logic [23:0]                   frame_addr_o
);
  localparam int unsigned LEN_W   = $clog2(MAX_LEN);
  localparam int unsigned CNT_MAX = PAY_START + MAX_LEN;
  localparam int unsigned CNT_W   = $clog2(CNT_MAX + 1);

  logic             byte_vld, cs_end, push;
  logic [7:0]       byte_val, tx_byte, push_data;
  logic [CNT_W-1:0] byte_idx, byte_cnt;
  logic [IRQ_N-1:0] ev;

  spi_tpm_rx #(.CNT_W(CNT_W), .CNT_MAX(CNT_MAX)) u_rx (
    .clk(clk), .rst(rst),
    .csb_i(spi_csb_i), .sck_i(spi_sck_i), .mosi_i(spi_mosi_i),
    .tx_byte_i(tx_byte), .miso_o(spi_miso_o),
    .byte_vld_o(byte_vld), .byte_o(byte_val),
    .byte_idx_o(byte_idx), .byte_cnt_o(byte_cnt), .cs_end_o(cs_end)
  );

  spi_tpm_frame #(.CNT_W(CNT_W), .LEN_W(LEN_W)) u_frame (
    .clk(clk), .rst(rst),
    .byte_vld_i(byte_vld), .byte_i(byte_val),
    .byte_idx_i(byte_idx), .byte_cnt_i(byte_cnt),
    .cs_end_i(cs_end), .rd_byte_i(rd_byte_i),
    .tx_byte_o(tx_byte), .push_o(push), .push_data_o(push_data),
    .ev_o(ev), .cmd_o(frame_cmd_o), .addr_o(frame_addr_o)
  );

  spi_tpm_fifo #(.DW(8), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst(rst),
    .push_i(push), .wdata_i(push_data),
    .pop_i(wf_pop_i), .rdata_o(wf_rdata_o), .depth_o(wf_depth_o)
  );

  spi_tpm_irq #(.N(IRQ_N)) u_irq (
    .clk(clk), .rst(rst),
    .ev_i(ev), .en_i(irq_en_i), .clr_i(irq_clr_i),
    .status_o(irq_status_o), .irq_o(irq_o)
  );
endmodule

// File: tb/tb_spi_tpm_cmpl.sv
`timescale 1ns/1ps
module tb_spi_tpm_cmpl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        csb = 1'b1, sck = 1'b0, mosi = 1'b0;
  logic        miso;
  logic [7:0]  rd_byte = 8'h00;
  logic        pop = 1'b0;
  logic [7:0]  rdata;
  logic [6:0]  depth;
  logic [2:0]  en = 3'b000, clr = 3'b000, status;
  logic        irq;
  logic [7:0]  fcmd;
  logic [23:0] faddr;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  spi_tpm_cmpl dut (
    .clk(clk), .rst(rst),
    .spi_csb_i(csb), .spi_sck_i(sck), .spi_mosi_i(mosi), .spi_miso_o(miso),
    .rd_byte_i(rd_byte), .wf_pop_i(pop), .wf_rdata_o(rdata), .wf_depth_o(depth),
    .irq_en_i(en), .irq_clr_i(clr), .irq_status_o(status), .irq_o(irq),
    .frame_cmd_o(fcmd), .frame_addr_o(faddr)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
    for (int i = 7; i >= 0; i--) begin
      mosi = tx[i];
      wclk(8);
      rx[i] = miso;
      sck = 1'b1;
      wclk(8);
      sck = 1'b0;
    end
  endtask

  task automatic cs_low();
    csb = 1'b0;
    wclk(8);
  endtask

  task automatic cs_high();
    wclk(8);
    csb = 1'b1;
    wclk(16);
  endtask

  task automatic header(input logic [7:0] cmd, input logic [23:0] addr);
    logic [7:0] r;
    xfer(cmd, r);
    xfer(addr[23:16], r);
    xfer(addr[15:8], r);
    xfer(addr[7:0], r);
  endtask

  task automatic wait_ready(input string req);
    logic [7:0] r;
    xfer(8'h00, r);
    check({req, " wait byte"}, r, 8'h00);
    xfer(8'h00, r);
    check({req, " ready byte"}, r, 8'h01);
  endtask

  task automatic pop_chk(input string req, input logic [7:0] exp);
    pop = 1'b1;
    wclk(1);
    pop = 1'b0;
    check(req, rdata, exp);
  endtask

  task automatic clear(input logic [2:0] m);
    clr = m;
    wclk(1);
    clr = 3'b000;
    wclk(2);
  endtask

  task automatic t_reset();
    check("R9 reset status", status, 3'b000);
    check("R7 reset depth", depth, 0);
    check("R10 reset irq", irq, 0);
    check("R11 reset miso", miso, 0);
  endtask

  task automatic t_write4();
    logic [7:0] r;
    cs_low();
    header(8'h03, 24'hD40024);
    wclk(16);
    check("R3 header done", status, 3'b001);
    check("R2 address", faddr, 24'hD40024);
    wait_ready("R2");
    xfer(8'hA1, r); xfer(8'hB2, r); xfer(8'hC3, r); xfer(8'hD4, r);
    wclk(16);
    check("R4 no write done before cs", status, 3'b001);
    cs_high();
    check("R4 write done", status, 3'b011);
    check("R7 depth 4", depth, 4);
    pop_chk("R7 pop 0", 8'hA1);
    pop_chk("R7 pop 1", 8'hB2);
    pop_chk("R7 pop 2", 8'hC3);
    pop_chk("R7 pop 3", 8'hD4);
    check("R7 depth drained", depth, 0);
    clear(3'b001);
    check("R9 clear header only", status, 3'b010);
    clear(3'b010);
    check("R9 clear write", status, 3'b000);
  endtask

  task automatic t_read();
    logic [7:0] r;
    rd_byte = 8'h5A;
    cs_low();
    header(8'h81, 24'h000102);
    wclk(16);
    check("R5 read done before cs", status, 3'b101);
    check("R1 read cmd", fcmd, 8'h81);
    wait_ready("R2 read");
    xfer(8'hFF, r);
    check("R11 read payload 0", r, 8'h5A);
    rd_byte = 8'hC3;
    xfer(8'hFF, r);
    check("R11 read payload 1", r, 8'hC3);
    cs_high();
    check("R4 no write done on read", status, 3'b101);
    check("R1 read stores nothing", depth, 0);
    clear(3'b111);
  endtask

  task automatic t_abort();
    logic [7:0] r;
    cs_low();
    xfer(8'h03, r);
    xfer(8'h12, r);
    cs_high();
    check("R6 aborted no status", status, 3'b000);
    check("R6 aborted no data", depth, 0);
    cs_low();
    header(8'h00, 24'h0A0B0C);
    wait_ready("R6 restart");
    xfer(8'h77, r);
    xfer(8'h88, r);
    cs_high();
    check("R6 restart address", faddr, 24'h0A0B0C);
    check("R1 extra bytes dropped", depth, 1);
    pop_chk("R1 single byte", 8'h77);
    check("R4 write done after restart", status, 3'b011);
  endtask

  task automatic t_enable();
    en = 3'b000;
    wclk(3);
    check("R10 disabled irq low", irq, 0);
    en = 3'b100;
    wclk(3);
    check("R10 unrelated enable", irq, 0);
    en = 3'b010;
    wclk(3);
    check("R10 enabled irq high", irq, 1);
    clear(3'b010);
    wclk(2);
    check("R10 irq drops after clear", irq, 0);
    check("R9 other bit kept", status, 3'b001);
    clear(3'b001);
    en = 3'b000;
  endtask

  task automatic t_full();
    logic [7:0] r;
    cs_low();
    header(8'h3F, 24'h000024);
    wait_ready("R2 long");
    for (int i = 0; i < 64; i++) xfer(8'(i), r);
    cs_high();
    check("R7 depth 64", depth, 64);
    cs_low();
    header(8'h03, 24'h000024);
    wait_ready("R2 overflow");
    for (int i = 0; i < 4; i++) xfer(8'hEE, r);
    cs_high();
    check("R8 depth held at full", depth, 64);
    for (int i = 0; i < 64; i++) pop_chk("R8 contents kept", 8'(i));
    check("R7 drained", depth, 0);
    clear(3'b111);
  endtask

  initial begin
    wclk(5);
    rst = 1'b0;
    wclk(3);
    t_reset();
    t_write4();
    t_read();
    t_abort();
    t_enable();
    t_full();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule